// File: doc/BRIEF.md
# Serial ADC Interface Sequencer

This block is the digital control for an 8-bit successive-approximation converter that is reached over a four-wire serial port. Each exchange has eight SCLK periods. The host shifts a 5-bit multiplexer code in on SCLK rising edges. At the same time the previous conversion result leaves, MSB first, on the data output. The eighth SCLK falling edge closes the exchange and starts a conversion. The conversion steps an 8-bit trial word out to an external DAC and reads back one comparator bit per core cycle.

The whole block runs on one free-running core (conversion) clock. Chip select, SCLK and the serial input are sampled into that domain. Chip select passes through a two-sample agreement filter, so a pulse shorter than one core period cannot start, end or abort anything. The output driver is different: it follows the raw chip-select pin, so the MSB is on the line as soon as the host selects the device. A conversion has a fixed length of CONV_CYCLES core cycles. While it runs, the serial port is deaf. When chip select has stayed low through the conversion, the next exchange opens the moment the result lands.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset, sdo_oe is 0 while cs_n is high, and res_valid, chan_on, vtest_on, logic_test, sample_en and dac_word are all 0. The output shift register holds 0, so the first exchange reads 0x00.
- R2: When cs_n falls, sdo_oe goes to 1 and sdo shows bit 7 of the held result before the next clock edge. Bits 6 down to 0 follow, one on each of the next seven SCLK falling edges.
- R3: The address is taken MSB first from sdi on the first five SCLK rising edges of an exchange, and the five bits become mux_sel together. Rising edges 6 to 8 leave mux_sel unchanged whatever sdi carries. sample_en is 1 from the fifth rising edge until the eighth falling edge.
- R4: The eighth SCLK falling edge starts a conversion of exactly CONV_CYCLES core cycles (26 to 32, default 28). The SAR decides bit 7 down to bit 0, one per cycle. dac_word carries the bits already kept plus the bit under test. A bit is kept when cmp is 1. The result reaches the output shift register only when the conversion ends, and res_valid is then 1.
- R5: If cs_n stays low through a conversion, SCLK edges during the conversion are ignored and sdo is driven low. At the end, sdo shows the new MSB and the next exchange proceeds without cs_n toggling.
- R6: While cs_n is high, sdo_oe is 0 and SCLK has no effect. Raising cs_n during a conversion and keeping it high until the end leaves the result intact.
- R7: A chip-select pulse, high or low, shorter than one core period is ignored. A level that holds for two consecutive core-clock samples is recognised, 2 to 3 cycles after the pin changes.
- R8: A recognised cs_n rise during an exchange that has seen at least one SCLK edge aborts the exchange. A recognised cs_n fall during a conversion, after cs_n went high in that conversion, aborts the conversion and opens a new exchange. After either abort, res_valid is 0 until a conversion completes. If such a fall is recognised in the last conversion cycle, the conversion completes instead.
- R9: Decoding of the 5-bit code: 0 to 18 assert chan_on, with mux_sel naming the channel. 19 asserts vtest_on (half-scale test voltage). 20 to 23 assert none of the three. 24 to 31 (top two bits 11) assert logic_test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (conversion) clock, free running |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial address input |
| cmp | input | 1 | Comparator result for the current trial word |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Output enable for sdo (1 = driven, 0 = high impedance) |
| mux_sel | output | 5 | Latched multiplexer code |
| chan_on | output | 1 | An input channel is connected |
| vtest_on | output | 1 | The internal half-scale test voltage is connected |
| logic_test | output | 1 | Logic test mode flag |
| sample_en | output | 1 | 1 = track the selected input, 0 = hold |
| dac_word | output | 8 | SAR trial word for the DAC, 0 when not converting |
| res_valid | output | 1 | The held result comes from a completed conversion |

## Verification
Two functions can fall in the same core cycle: completion of a conversion and recognition of a chip-select fall that would abort it. The bench raises cs_n just after the eighth falling edge. It then lowers cs_n so that the filtered fall lands either on the final conversion cycle or one cycle earlier. In the first case res_valid must be 1 and the next exchange must return the new result. In the second case res_valid must be 0, and it must return to 1 only after another full exchange and conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_XFER = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/csel_filter.sv
// Chip-select filter: the filtered level follows the pin only after AGREE
// consecutive core-clock samples agree.
module csel_filter #(
  parameter int AGREE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_raw,
  output logic cs_filt
);
  logic [AGREE-1:0] hist_q, hist_d;
  logic             filt_q, filt_d;

  always_comb begin
    hist_d = {hist_q[AGREE-2:0], cs_n_raw};
    filt_d = filt_q;
    if (&hist_q)
      filt_d = 1'b1;
    else if (~|hist_q)
      filt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign cs_filt = filt_q;

  // R7: a change of the filtered level needs two agreeing pin samples
  a_r7_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |->
      ($past(cs_n_raw, 2) == filt_q && $past(cs_n_raw, 3) == filt_q));
endmodule

// File: rtl/sclk_sampler.sv
// Samples SCLK and SDI into the core domain and flags SCLK edges.
module sclk_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sdi,
  output logic rise,
  output logic fall,
  output logic sdi_smp
);
  logic [STAGES-1:0] sc_q;
  logic              sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
      sd_q <= 1'b0;
    end else begin
      sc_q <= {sc_q[STAGES-2:0], sclk};
      sd_q <= sdi;
    end
  end

  assign rise    = sc_q[STAGES-2] & ~sc_q[STAGES-1];
  assign fall    = ~sc_q[STAGES-2] & sc_q[STAGES-1];
  assign sdi_smp = sd_q;
endmodule

// File: rtl/addr_decode.sv
// Splits the latched multiplexer code into channel / test voltage / logic test.
module addr_decode #(
  parameter int AW     = 5,
  parameter int NUM_CH = 19
) (
  input  logic [AW-1:0] code,
  output logic          chan_on,
  output logic          vtest_on,
  output logic          logic_test
);
  localparam logic [AW-1:0] VTEST_CODE = AW'(NUM_CH);

  always_comb begin
    logic_test = &code[AW-1:AW-2];
    chan_on    = !logic_test && (code < VTEST_CODE);
    vtest_on   = !logic_test && (code == VTEST_CODE);
  end
endmodule

// File: rtl/sar_core.sv
// Successive-approximation engine: one bit per cycle, MSB first, then
// idle padding up to CONV_CYCLES.
module sar_core #(
  parameter int DW          = 8,
  parameter int CONV_CYCLES = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          cmp_i,
  output logic [DW-1:0] trial_o,
  output logic          done_o,
  output logic [DW-1:0] result_o
);
  localparam int          CW   = $clog2(CONV_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] res_q, res_d;
  logic [DW-1:0] mask_q, mask_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d  = cnt_q;
    res_d  = res_q;
    mask_d = mask_q;
    run_d  = run_q;
    done_o = run_q && (cnt_q == LAST);
    if (start_i) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      res_d  = '0;
      mask_d = {1'b1, {(DW-1){1'b0}}};
    end else if (run_q) begin
      if (cmp_i && (|mask_q))
        res_d = res_q | mask_q;
      mask_d = mask_q >> 1;
      cnt_d  = cnt_q + 1'b1;
      if (done_o || abort_i)
        run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      res_q  <= '0;
      mask_q <= '0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      res_q  <= res_d;
      mask_q <= mask_d;
      run_q  <= run_d;
    end
  end

  assign trial_o  = run_q ? (res_q | mask_q) : '0;
  assign result_o = res_d;

  // R4: at most one bit is under test in any cycle
  a_r4_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> $onehot0(mask_q));
  // R4: a conversion is never shorter than its full length
  a_r4_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !run_q) |=> !done_o);
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adcseq_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 5,
  parameter int NUM_CH      = 19,
  parameter int CONV_CYCLES = 28,
  parameter int CS_AGREE    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          cmp,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] mux_sel,
  output logic          chan_on,
  output logic          vtest_on,
  output logic          logic_test,
  output logic          sample_en,
  output logic [DW-1:0] dac_word,
  output logic          res_valid
);
  localparam int            CNT_W    = $clog2(DW + 1);
  localparam logic [AW-1:0] IDLE_CODE = AW'(NUM_CH + 1);

  logic          cs_f;
  logic          sc_rise, sc_fall, sdi_smp;
  logic          sar_start, sar_abort, sar_done;
  logic [DW-1:0] sar_result;

  seq_state_e    state_q, state_d;
  logic [CNT_W-1:0] rise_cnt_q, rise_cnt_d, fall_cnt_q, fall_cnt_d;
  logic [AW-1:0] addr_sh_q, addr_sh_d, addr_q, addr_d;
  logic [DW-1:0] out_sh_q, out_sh_d;
  logic          samp_q, samp_d, valid_q, valid_d, left_q, left_d;

  csel_filter #(.AGREE(CS_AGREE)) u_csf (
    .clk(clk), .rst_n(rst_n), .cs_n_raw(cs_n), .cs_filt(cs_f));

  sclk_sampler #(.STAGES(2)) u_sck (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
    .rise(sc_rise), .fall(sc_fall), .sdi_smp(sdi_smp));

  sar_core #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_sar (
    .clk(clk), .rst_n(rst_n), .start_i(sar_start), .abort_i(sar_abort),
    .cmp_i(cmp), .trial_o(dac_word), .done_o(sar_done), .result_o(sar_result));

  addr_decode #(.AW(AW), .NUM_CH(NUM_CH)) u_dec (
    .code(addr_q), .chan_on(chan_on), .vtest_on(vtest_on), .logic_test(logic_test));

  always_comb begin
    state_d    = state_q;
    rise_cnt_d = rise_cnt_q;
    fall_cnt_d = fall_cnt_q;
    addr_sh_d  = addr_sh_q;
    addr_d     = addr_q;
    out_sh_d   = out_sh_q;
    samp_d     = samp_q;
    valid_d    = valid_q;
    left_d     = left_q;
    sar_start  = 1'b0;
    sar_abort  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (!cs_f) begin
          state_d    = SEQ_XFER;
          rise_cnt_d = '0;
          fall_cnt_d = '0;
        end
      end
      SEQ_XFER: begin
        if (cs_f) begin
          state_d = SEQ_IDLE;
          samp_d  = 1'b0;
          if ((rise_cnt_q != '0) || (fall_cnt_q != '0))
            valid_d = 1'b0;
        end else begin
          if (sc_rise && (rise_cnt_q != CNT_W'(DW))) begin
            rise_cnt_d = rise_cnt_q + 1'b1;
            if (rise_cnt_q < CNT_W'(AW))
              addr_sh_d = {addr_sh_q[AW-2:0], sdi_smp};
            if (rise_cnt_q == CNT_W'(AW - 1)) begin
              addr_d = {addr_sh_q[AW-2:0], sdi_smp};
              samp_d = 1'b1;
            end
          end
          if (sc_fall) begin
            fall_cnt_d = fall_cnt_q + 1'b1;
            out_sh_d   = {out_sh_q[DW-2:0], 1'b0};
            if (fall_cnt_q == CNT_W'(DW - 1)) begin
              state_d   = SEQ_CONV;
              samp_d    = 1'b0;
              left_d    = 1'b0;
              sar_start = 1'b1;
            end
          end
        end
      end
      SEQ_CONV: begin
        if (cs_f)
          left_d = 1'b1;
        if (sar_done) begin
          out_sh_d = sar_result;
          valid_d  = 1'b1;
          if (!cs_f) begin
            state_d    = SEQ_XFER;
            rise_cnt_d = '0;
            fall_cnt_d = '0;
          end else begin
            state_d = SEQ_IDLE;
          end
        end else if (left_q && !cs_f) begin
          sar_abort  = 1'b1;
          valid_d    = 1'b0;
          state_d    = SEQ_XFER;
          rise_cnt_d = '0;
          fall_cnt_d = '0;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      rise_cnt_q <= '0;
      fall_cnt_q <= '0;
      addr_sh_q  <= '0;
      addr_q     <= IDLE_CODE;
      out_sh_q   <= '0;
      samp_q     <= 1'b0;
      valid_q    <= 1'b0;
      left_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      rise_cnt_q <= rise_cnt_d;
      fall_cnt_q <= fall_cnt_d;
      addr_sh_q  <= addr_sh_d;
      addr_q     <= addr_d;
      out_sh_q   <= out_sh_d;
      samp_q     <= samp_d;
      valid_q    <= valid_d;
      left_q     <= left_d;
    end
  end

  assign sdo       = out_sh_q[DW-1];
  assign sdo_oe    = ~cs_n;
  assign mux_sel   = addr_q;
  assign sample_en = samp_q;
  assign res_valid = valid_q;

  // R3: once five address bits are in, later rising edges keep the code
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_XFER && rise_cnt_q >= CNT_W'(AW)) |=> $stable(addr_q));
  // R5: SCLK cannot move the output register while a conversion runs
  a_r5_conv_blocks_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONV && !sar_done) |=> $stable(out_sh_q));
  // R8: the valid flag is only set by a finishing conversion
  a_r8_valid_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(sar_done));
  // R9: at most one decode outcome at a time
  a_r9_decode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_on, vtest_on, logic_test}));
  // R3: sampling is never active during a conversion
  a_r3_hold_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONV) |-> !sample_en);
endmodule

// File: tb/sim_adc_serial_seq.sv
module sim_adc_serial_seq;
  localparam int CONV = 28;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sclk, sdi, cmp;
  logic       sdo, sdo_oe, chan_on, vtest_on, logic_test, sample_en, res_valid;
  logic [4:0] mux_sel;
  logic [7:0] dac_word, vin;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_res;
  logic       exp_valid;

  always #2 clk = ~clk;

  adc_serial_seq u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .cmp(cmp),
    .sdo(sdo), .sdo_oe(sdo_oe), .mux_sel(mux_sel), .chan_on(chan_on),
    .vtest_on(vtest_on), .logic_test(logic_test), .sample_en(sample_en),
    .dac_word(dac_word), .res_valid(res_valid));

  function automatic logic [7:0] chan_val(input int k);
    return 8'((k * 53 + 29) % 256);
  endfunction

  function automatic logic [7:0] code_val(input int code);
    if (code < 19) return chan_val(code);
    if (code == 19) return 8'd128;
    return 8'd0;
  endfunction

  // behavioural analog front end: mux, test voltage, comparator
  always_comb begin
    if (chan_on) vin = chan_val(int'(mux_sel));
    else if (vtest_on) vin = 8'd128;
    else vin = 8'd0;
  end
  assign cmp = (vin >= dac_word);

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock model of the output enable
  always @(posedge clk)
    if (rst_n) check("R6 sdo_oe follows cs_n", {31'b0, sdo_oe}, {31'b0, !cs_n});

  // eight SCLK periods; returns at the negedge of the 8th falling edge
  task automatic shift8(input logic [4:0] addr, output logic [7:0] got);
    got[7] = sdo;
    for (int i = 0; i < 8; i++) begin
      sdi  = (i < 5) ? addr[4-i] : 1'b1;
      sclk = 1'b1;
      tick(HALF);
      if (i == 3) check("R3 sample_en low before 5th rise", {31'b0, sample_en}, 0);
      if (i == 4) begin
        check("R3 mux_sel after 5th rise", {27'b0, mux_sel}, {27'b0, addr});
        check("R3 sample_en high", {31'b0, sample_en}, 1);
        check("R9 chan_on", {31'b0, chan_on}, {31'b0, addr < 5'd19});
        check("R9 vtest_on", {31'b0, vtest_on}, {31'b0, addr == 5'd19});
        check("R9 logic_test", {31'b0, logic_test}, {31'b0, addr >= 5'd24});
      end
      sclk = 1'b0;
      if (i < 7) begin
        tick(HALF);
        got[6-i] = sdo;
      end
    end
  endtask

  task automatic cs_fall_check();
    cs_n = 1'b0;
    #1;
    check("R2 sdo_oe at cs fall", {31'b0, sdo_oe}, 1);
    if (exp_valid) check("R2 msb at cs fall", {31'b0, sdo}, {31'b0, exp_res[7]});
    tick(4);
  endtask

  // complete exchange with cs_n raised during the conversion
  task automatic xfer_cs(input logic [4:0] addr);
    logic [7:0] got;
    cs_fall_check();
    shift8(addr, got);
    if (exp_valid) check("R2 R4 read result", {24'b0, got}, {24'b0, exp_res});
    tick(2);
    check("R3 sample_en low in conversion", {31'b0, sample_en}, 0);
    cs_n = 1'b1;
    tick(CONV + 8);
    exp_res = code_val(int'(addr));
    exp_valid = 1'b1;
    check("R6 R4 valid after conversion", {31'b0, res_valid}, 1);
    check("R3 mux_sel kept after rises 6-8", {27'b0, mux_sel}, {27'b0, addr});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #600000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] got;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    exp_res = 8'd0; exp_valid = 1'b1;
    tick(3);
    check("R1 sdo_oe reset", {31'b0, sdo_oe}, 0);
    check("R1 res_valid reset", {31'b0, res_valid}, 0);
    check("R1 chan_on reset", {31'b0, chan_on}, 0);
    check("R1 vtest_on reset", {31'b0, vtest_on}, 0);
    check("R1 logic_test reset", {31'b0, logic_test}, 0);
    check("R1 sample_en reset", {31'b0, sample_en}, 0);
    check("R1 dac_word reset", {24'b0, dac_word}, 0);
    rst_n = 1'b1;
    tick(2);

    // R1: the first read returns zero; then a run of codes (R4, R9)
    xfer_cs(5'd7);
    xfer_cs(5'd19);
    xfer_cs(5'd18);
    xfer_cs(5'd21);
    xfer_cs(5'd26);
    xfer_cs(5'd3);

    // R6: SCLK toggled with cs_n high has no effect
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; tick(3); sclk = 1'b0; tick(3);
    end
    xfer_cs(5'd12);

    // R5: cs_n held low through the conversion, stray SCLK edges ignored
    cs_fall_check();
    shift8(5'd9, got);
    check("R6 read after idle SCLK", {24'b0, got}, {24'b0, exp_res});
    tick(3);
    check("R5 sdo low during conversion", {31'b0, sdo}, 0);
    sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    cs_n = 1'b1; #1; cs_n = 1'b0;   // R7: sub-period glitch while converting
    tick(CONV + 4);
    exp_res = code_val(9);
    check("R5 R7 valid after conversion", {31'b0, res_valid}, 1);
    check("R5 new msb without cs toggle", {31'b0, sdo}, {31'b0, exp_res[7]});
    check("R5 sdo_oe still on", {31'b0, sdo_oe}, 1);
    shift8(5'd1, got);
    check("R5 back-to-back read", {24'b0, got}, {24'b0, exp_res});
    tick(1);
    cs_n = 1'b1;
    tick(CONV + 8);
    exp_res = code_val(1);

    // R7: a sub-period high glitch inside an exchange is ignored
    cs_n = 1'b0;
    tick(4);
    sdi = 1'b0; sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
    cs_n = 1'b1; #1; cs_n = 1'b0;
    tick(3);
    check("R7 glitch ignored, valid kept", {31'b0, res_valid}, 1);
    cs_n = 1'b1;
    tick(6);
    check("R8 abort of exchange clears valid", {31'b0, res_valid}, 0);
    exp_valid = 1'b0;

    // R7: a two-cycle high pulse inside an exchange is recognised
    xfer_cs(5'd16);
    check("R8 valid back after full conversion", {31'b0, res_valid}, 1);
    cs_n = 1'b0;
    tick(4);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
    end
    cs_n = 1'b1; tick(2); cs_n = 1'b0;
    tick(6);
    check("R7 two-cycle pulse aborts", {31'b0, res_valid}, 0);
    exp_valid = 1'b0;
    shift8(5'd5, got);
    tick(2);
    check("R8 still invalid during exchange", {31'b0, res_valid}, 0);
    cs_n = 1'b1;
    tick(CONV + 8);
    exp_res = code_val(5); exp_valid = 1'b1;
    check("R8 valid after recovery", {31'b0, res_valid}, 1);

    // R8: filtered fall on the last conversion cycle -> completion wins
    cs_fall_check();
    shift8(5'd11, got);
    check("R4 read before priority case", {24'b0, got}, {24'b0, exp_res});
    tick(1);
    cs_n = 1'b1;
    tick(CONV - 3);
    cs_n = 1'b0;
    tick(6);
    exp_res = code_val(11);
    check("R8 completion beats abort", {31'b0, res_valid}, 1);
    check("R8 new msb on completion", {31'b0, sdo}, {31'b0, exp_res[7]});
    shift8(5'd14, got);
    check("R8 result after tie", {24'b0, got}, {24'b0, exp_res});

    // R8: filtered fall one cycle earlier -> conversion aborted
    tick(1);
    cs_n = 1'b1;
    tick(CONV - 4);
    cs_n = 1'b0;
    tick(6);
    check("R8 fall before last cycle aborts", {31'b0, res_valid}, 0);
    exp_valid = 1'b0;
    shift8(5'd2, got);
    tick(1);
    cs_n = 1'b1;
    tick(CONV + 8);
    exp_res = code_val(2); exp_valid = 1'b1;
    check("R8 valid after new conversion", {31'b0, res_valid}, 1);
    xfer_cs(5'd0);
    summary();
  end
endmodule